// File: doc/BRIEF.md
# VPW Bus Symbol Decoder

This block receives the level of a single-wire bus that uses variable pulse width coding. The bus level is passed through a synchronizer. The block counts microsecond ticks between level changes and decides what each interval means. The meaning depends on the length of the interval and on the level the bus held during it. A short passive interval is a 0 and a long passive interval is a 1. On the active level the two lengths swap meaning. Long active intervals open a frame. Long passive intervals close the data part of a frame, then close the frame, then mark the bus as idle.

The decoded bits are shifted into bytes, most significant bit first. Each complete byte is presented with a one-cycle strobe. Single-cycle flags report frame start, end of data, end of frame, bus idle and bus break. An error flag reports bits that arrive outside a frame, a byte that does not start on the passive level, and data that ends part-way through a byte. The `us_tick` input supplies the time base; it must pulse for one clock cycle per microsecond.

Top module: `vpw_decoder`

## Requirements
- R1: A passive interval of 34 to 95 ticks decodes as bit 0, and a passive interval of 96 to 162 ticks decodes as bit 1.
- R2: An active interval of 34 to 95 ticks decodes as bit 1, and an active interval of 96 to 162 ticks decodes as bit 0.
- R3: An active interval of 163 to 239 ticks pulses `frame_start` once the interval ends, opens a frame and clears byte assembly.
- R4: When an active level has been held for 240 ticks, `bus_break` pulses once and any open frame is closed.
- R5: When a passive level inside a frame has been held for 163 ticks, `data_end` pulses. If the bit count of the byte in progress is not zero, `sym_error` pulses in the same cycle and assembly is cleared.
- R6: When a passive level inside a frame has been held for 239 ticks, `frame_end` pulses and the frame closes.
- R7: When a passive level has been held for 300 ticks, `bus_idle` pulses once, whether or not a frame is open.
- R8: An interval shorter than 34 ticks produces no bit, no flag and no error. Timing restarts from its closing edge.
- R9: A decoded bit while no frame is open pulses `sym_error` and yields no byte.
- R10: The first bit of every byte must come from a passive interval. An active bit in that position pulses `sym_error` and clears assembly, and the frame stays open.
- R11: Bits enter most significant bit first. On the eighth bit, `byte_valid` pulses for one cycle, and `byte_data` takes the byte and holds it until the next strobe.
- R12: While `rst_n` is low, all flags are low and `byte_data` is zero. After reset no frame is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| bus_in | input | 1 | Raw bus level, 1 = active, asynchronous |
| byte_data | output | 8 | Last assembled byte |
| byte_valid | output | 1 | One-cycle strobe for a new byte |
| frame_start | output | 1 | Start-of-frame symbol decoded |
| data_end | output | 1 | End-of-data reached |
| frame_end | output | 1 | End-of-frame reached |
| bus_idle | output | 1 | Bus idle reached |
| bus_break | output | 1 | Break reached |
| sym_error | output | 1 | Illegal bit position or bit outside a frame |

## Verification
The hardest state to reach from the ports is an active bit that lands in the first position of a byte. Level alternation normally prevents this. The stimulus reaches it by placing a 33-tick passive pulse straight after a start-of-frame symbol. The decoder discards that pulse as a glitch, so the next active pulse falls on bit position zero. The interval boundaries 33/34, 95/96, 162/163 and 239/240 are hit exactly. The same durations are used on both levels so that the level-dependent bit value is exposed.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

  // Meaning of one closed interval.
  typedef enum logic [2:0] {
    SYM_NONE,
    SYM_GLITCH,
    SYM_BIT0,
    SYM_BIT1,
    SYM_SOF,
    SYM_HOLD
  } vpw_sym_e;

  // Positions of the live threshold detectors.
  localparam int HIT_EOD  = 0;
  localparam int HIT_EOF  = 1;
  localparam int HIT_IDLE = 2;
  localparam int HIT_BRK  = 3;
  localparam int N_HITS   = 4;

  // Bit value from level and length: a long interval inverts the level.
  function automatic logic vpw_bit_value(input logic act, input logic is_long);
    return act ^ is_long;
  endfunction

  // Classify an interval of len ticks at level act.
  function automatic vpw_sym_e vpw_classify(
    input logic        act,
    input int unsigned len,
    input int unsigned glitch_us,
    input int unsigned split_us,
    input int unsigned long_end_us,
    input int unsigned break_us
  );
    if (len < glitch_us)      return SYM_GLITCH;
    if (len < long_end_us)
      return vpw_bit_value(act, len >= split_us) ? SYM_BIT1 : SYM_BIT0;
    if (act && len < break_us) return SYM_SOF;
    return SYM_HOLD;
  endfunction

  // True on the tick that moves the count onto thr.
  function automatic logic vpw_reaches(input logic tick, input int unsigned cnt,
                                       input int unsigned thr);
    return tick && (cnt + 1 == thr);
  endfunction

endpackage

// File: rtl/vpw_sync.sv
module vpw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic level,
  output logic level_q,
  output logic toggle
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], bus_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign level  = chain[STAGES-1];
  assign toggle = level ^ level_q;
endmodule

// File: rtl/vpw_timer.sv
module vpw_timer
  import vpw_pkg::*;
#(
  parameter int unsigned EOD_US   = 163,
  parameter int unsigned EOF_US   = 239,
  parameter int unsigned IDLE_US  = 300,
  parameter int unsigned BREAK_US = 240,
  parameter int          CNT_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              level,
  input  logic              toggle,
  output logic [CNT_W-1:0]  cnt,
  output logic [N_HITS-1:0] hits
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(IDLE_US);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (toggle)             cnt <= '0;
    else if (tick && cnt != SAT) cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < N_HITS; g++) begin : g_hit
    localparam int unsigned THR = (g == HIT_EOD)  ? EOD_US  :
                                  (g == HIT_EOF)  ? EOF_US  :
                                  (g == HIT_IDLE) ? IDLE_US : BREAK_US;
    localparam logic ON_ACT = (g == HIT_BRK);
    assign hits[g] = !toggle && (level == ON_ACT) &&
                     vpw_reaches(tick, 32'(cnt), THR);
  end
endmodule

// File: rtl/vpw_classify.sv
module vpw_classify
  import vpw_pkg::*;
#(
  parameter int unsigned GLITCH_US  = 34,
  parameter int unsigned SPLIT_US   = 96,
  parameter int unsigned SOF_MIN_US = 163,
  parameter int unsigned BREAK_US   = 240,
  parameter int          CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             toggle,
  input  logic             ended_act,
  input  logic [CNT_W-1:0] cnt,
  output logic             sym_valid,
  output vpw_sym_e         sym,
  output logic             sym_act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_valid <= 1'b0;
      sym       <= SYM_NONE;
      sym_act   <= 1'b0;
    end else begin
      sym_valid <= toggle;
      sym_act   <= ended_act;
      sym       <= toggle ? vpw_classify(ended_act, 32'(cnt), GLITCH_US, SPLIT_US,
                                         SOF_MIN_US, BREAK_US)
                          : SYM_NONE;
    end
  end
endmodule

// File: rtl/vpw_assembler.sv
module vpw_assembler
  import vpw_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  vpw_sym_e          sym,
  input  logic              sym_act,
  input  logic [N_HITS-1:0] hits,
  output logic [BITS-1:0]   byte_data,
  output logic              byte_valid,
  output logic              frame_start,
  output logic              data_end,
  output logic              frame_end,
  output logic              bus_idle,
  output logic              bus_break,
  output logic              sym_error,
  output logic              in_frame
);
  localparam int IDX_W = $clog2(BITS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BITS - 1);

  logic [IDX_W-1:0] idx;
  logic [BITS-2:0]  shreg;
  logic             is_bit;
  logic             bit_val;

  assign is_bit  = sym_valid && (sym == SYM_BIT0 || sym == SYM_BIT1);
  assign bit_val = (sym == SYM_BIT1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_data   <= '0;
      byte_valid  <= 1'b0;
      frame_start <= 1'b0;
      data_end    <= 1'b0;
      frame_end   <= 1'b0;
      bus_idle    <= 1'b0;
      bus_break   <= 1'b0;
      sym_error   <= 1'b0;
      in_frame    <= 1'b0;
      idx         <= '0;
      shreg       <= '0;
    end else begin
      byte_valid  <= 1'b0;
      frame_start <= 1'b0;
      data_end    <= 1'b0;
      frame_end   <= 1'b0;
      bus_idle    <= 1'b0;
      bus_break   <= 1'b0;
      sym_error   <= 1'b0;

      if (sym_valid && sym == SYM_SOF) begin
        frame_start <= 1'b1;
        in_frame    <= 1'b1;
        idx         <= '0;
      end else if (is_bit) begin
        if (!in_frame || (idx == '0 && sym_act)) begin
          sym_error <= 1'b1;
          idx       <= '0;
        end else begin
          shreg <= {shreg[BITS-3:0], bit_val};
          if (idx == LAST) begin
            byte_valid <= 1'b1;
            byte_data  <= {shreg, bit_val};
            idx        <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end

      if (hits[HIT_EOD] && in_frame) begin
        data_end <= 1'b1;
        if (idx != '0) begin
          sym_error <= 1'b1;
          idx       <= '0;
        end
      end
      if (hits[HIT_EOF] && in_frame) begin
        frame_end <= 1'b1;
        in_frame  <= 1'b0;
        idx       <= '0;
      end
      if (hits[HIT_IDLE]) bus_idle <= 1'b1;
      if (hits[HIT_BRK]) begin
        bus_break <= 1'b1;
        in_frame  <= 1'b0;
        idx       <= '0;
      end
    end
  end
endmodule

// File: rtl/vpw_decoder.sv
module vpw_decoder
  import vpw_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned GLITCH_US   = 34,
  parameter int unsigned SPLIT_US    = 96,
  parameter int unsigned SOF_MIN_US  = 163,
  parameter int unsigned EOD_US      = 163,
  parameter int unsigned EOF_US      = 239,
  parameter int unsigned BREAK_US    = 240,
  parameter int unsigned IDLE_US     = 300,
  parameter int          BYTE_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 us_tick,
  input  logic                 bus_in,
  output logic [BYTE_BITS-1:0] byte_data,
  output logic                 byte_valid,
  output logic                 frame_start,
  output logic                 data_end,
  output logic                 frame_end,
  output logic                 bus_idle,
  output logic                 bus_break,
  output logic                 sym_error
);
  localparam int CNT_W = $clog2(IDLE_US + 1);

  // Internal events, named so that the bound checker can watch them.
  logic              lvl_sync_w;
  logic              lvl_end_w;
  logic              edge_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [N_HITS-1:0] hits_w;
  logic              sym_valid_w;
  vpw_sym_e          sym_w;
  logic              sym_act_w;
  logic              in_frame_w;

  vpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_in  (bus_in),
    .level   (lvl_sync_w),
    .level_q (lvl_end_w),
    .toggle  (edge_w)
  );

  vpw_timer #(
    .EOD_US   (EOD_US),
    .EOF_US   (EOF_US),
    .IDLE_US  (IDLE_US),
    .BREAK_US (BREAK_US),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (us_tick),
    .level  (lvl_sync_w),
    .toggle (edge_w),
    .cnt    (cnt_w),
    .hits   (hits_w)
  );

  vpw_classify #(
    .GLITCH_US  (GLITCH_US),
    .SPLIT_US   (SPLIT_US),
    .SOF_MIN_US (SOF_MIN_US),
    .BREAK_US   (BREAK_US),
    .CNT_W      (CNT_W)
  ) u_classify (
    .clk       (clk),
    .rst_n     (rst_n),
    .toggle    (edge_w),
    .ended_act (lvl_end_w),
    .cnt       (cnt_w),
    .sym_valid (sym_valid_w),
    .sym       (sym_w),
    .sym_act   (sym_act_w)
  );

  vpw_assembler #(.BITS(BYTE_BITS)) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_valid   (sym_valid_w),
    .sym         (sym_w),
    .sym_act     (sym_act_w),
    .hits        (hits_w),
    .byte_data   (byte_data),
    .byte_valid  (byte_valid),
    .frame_start (frame_start),
    .data_end    (data_end),
    .frame_end   (frame_end),
    .bus_idle    (bus_idle),
    .bus_break   (bus_break),
    .sym_error   (sym_error),
    .in_frame    (in_frame_w)
  );
endmodule

// File: rtl/vpw_decoder_chk.sv
module vpw_decoder_chk
  import vpw_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     lvl_sync,
  input logic     sym_valid,
  input vpw_sym_e sym,
  input logic     in_frame,
  input logic     byte_valid,
  input logic     frame_start,
  input logic     data_end,
  input logic     frame_end,
  input logic     bus_idle,
  input logic     bus_break,
  input logic     sym_error
);
  logic bit_sym;
  assign bit_sym = sym_valid && (sym == SYM_BIT0 || sym == SYM_BIT1);

  // R3
  sof_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> in_frame);

  // R4
  break_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_break |-> !in_frame);

  // R6
  eof_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !in_frame);

  // R5
  eod_passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_end |-> !$past(lvl_sync));

  // R7
  idle_passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !$past(lvl_sync));

  // R8
  glitch_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym == SYM_GLITCH) |=> !(sym_error || byte_valid || frame_start));

  // R9
  outside_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_sym && !in_frame) |=> sym_error);

  // R11
  byte_from_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(bit_sym));

  // R10
  err_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sym_error && byte_valid));
endmodule

bind vpw_decoder vpw_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lvl_sync    (lvl_sync_w),
  .sym_valid   (sym_valid_w),
  .sym         (sym_w),
  .in_frame    (in_frame_w),
  .byte_valid  (byte_valid),
  .frame_start (frame_start),
  .data_end    (data_end),
  .frame_end   (frame_end),
  .bus_idle    (bus_idle),
  .bus_break   (bus_break),
  .sym_error   (sym_error)
);

// File: tb/tb_vpw_decoder.sv
module tb_vpw_decoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, us_tick, bus_in;
  logic [7:0] byte_data;
  logic       byte_valid, frame_start, data_end, frame_end;
  logic       bus_idle, bus_break, sym_error;

  vpw_decoder dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_in(bus_in),
    .byte_data(byte_data), .byte_valid(byte_valid), .frame_start(frame_start),
    .data_end(data_end), .frame_end(frame_end), .bus_idle(bus_idle),
    .bus_break(bus_break), .sym_error(sym_error)
  );

  // Mask bits: 0 sof, 1 eod, 2 eof, 3 idle, 4 break, 5 error, 6 byte
  localparam logic [6:0] M_SOF = 7'h01, M_EOD = 7'h02, M_EOF = 7'h04,
                         M_IDLE = 7'h08, M_BRK = 7'h10, M_ERR = 7'h20,
                         M_BYTE = 7'h40;

  typedef struct packed {
    logic       lvl;
    logic [9:0] dur;
    logic [6:0] mask;
    logic [7:0] dat;
    logic [3:0] req;
  } vec_t;

  // Each row: hold level for dur ticks; mask = flags seen inside that hold.
  localparam int NV = 45;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'd320, M_IDLE, 8'h00, 4'd7},          // R7 idle after reset
    '{1'b1, 10'd200, 7'h00,  8'h00, 4'd3},          // R3 SOF pulse
    '{1'b0, 10'd128, M_SOF,  8'h00, 4'd3},          // R3 / R1 b7=1
    '{1'b1, 10'd128, 7'h00,  8'h00, 4'd2},          // R2 b6=0
    '{1'b0, 10'd128, 7'h00,  8'h00, 4'd1},          // R1 b5=1
    '{1'b1, 10'd128, 7'h00,  8'h00, 4'd2},          // R2 b4=0
    '{1'b0, 10'd64,  7'h00,  8'h00, 4'd1},          // R1 b3=0
    '{1'b1, 10'd64,  7'h00,  8'h00, 4'd2},          // R2 b2=1
    '{1'b0, 10'd64,  7'h00,  8'h00, 4'd1},          // R1 b1=0
    '{1'b1, 10'd64,  7'h00,  8'h00, 4'd2},          // R2 b0=1
    '{1'b0, 10'd64,  M_BYTE, 8'hA5, 4'd11},         // R11 byte A5, next b7=0
    '{1'b1, 10'd128, 7'h00,  8'h00, 4'd2},
    '{1'b0, 10'd128, 7'h00,  8'h00, 4'd1},
    '{1'b1, 10'd64,  7'h00,  8'h00, 4'd2},
    '{1'b0, 10'd128, 7'h00,  8'h00, 4'd1},
    '{1'b1, 10'd64,  7'h00,  8'h00, 4'd2},
    '{1'b0, 10'd64,  7'h00,  8'h00, 4'd1},
    '{1'b1, 10'd128, 7'h00,  8'h00, 4'd2},
    '{1'b0, 10'd320, M_BYTE|M_EOD|M_EOF|M_IDLE, 8'h3C, 4'd6},  // R6 R11
    '{1'b1, 10'd163, 7'h00,  8'h00, 4'd3},          // R3 lower edge
    '{1'b0, 10'd34,  M_SOF,  8'h00, 4'd3},          // R1 34 -> 0
    '{1'b1, 10'd95,  7'h00,  8'h00, 4'd2},          // R2 95 -> 1
    '{1'b0, 10'd96,  7'h00,  8'h00, 4'd1},          // R1 96 -> 1
    '{1'b1, 10'd162, 7'h00,  8'h00, 4'd2},          // R2 162 -> 0
    '{1'b0, 10'd162, 7'h00,  8'h00, 4'd1},          // R1 162 -> 1
    '{1'b1, 10'd34,  7'h00,  8'h00, 4'd2},          // R2 34 -> 1
    '{1'b0, 10'd95,  7'h00,  8'h00, 4'd1},          // R1 95 -> 0
    '{1'b1, 10'd96,  7'h00,  8'h00, 4'd2},          // R2 96 -> 0
    '{1'b0, 10'd320, M_BYTE|M_EOD|M_EOF|M_IDLE, 8'h6C, 4'd1},  // R1 R2 byte 6C
    '{1'b1, 10'd260, M_BRK,  8'h00, 4'd4},          // R4 break
    '{1'b0, 10'd320, M_IDLE, 8'h00, 4'd4},          // R4 no frame left
    '{1'b1, 10'd33,  7'h00,  8'h00, 4'd8},          // R8 glitch
    '{1'b0, 10'd320, M_IDLE, 8'h00, 4'd8},          // R8 ignored, idle again
    '{1'b1, 10'd64,  7'h00,  8'h00, 4'd9},
    '{1'b0, 10'd64,  M_ERR,  8'h00, 4'd9},          // R9 bit outside frame
    '{1'b1, 10'd200, M_ERR,  8'h00, 4'd9},          // R9
    '{1'b0, 10'd128, M_SOF,  8'h00, 4'd3},
    '{1'b1, 10'd128, 7'h00,  8'h00, 4'd2},
    '{1'b0, 10'd260, M_EOD|M_ERR|M_EOF, 8'h00, 4'd5},  // R5 EOD mid-byte
    '{1'b1, 10'd239, 7'h00,  8'h00, 4'd3},          // R3 upper edge, no break
    '{1'b0, 10'd33,  M_SOF,  8'h00, 4'd3},          // R3 / R8 glitch
    '{1'b1, 10'd64,  7'h00,  8'h00, 4'd10},
    '{1'b0, 10'd128, M_ERR,  8'h00, 4'd10},         // R10 active first bit
    '{1'b1, 10'd64,  7'h00,  8'h00, 4'd10},
    '{1'b0, 10'd320, M_EOD|M_ERR|M_EOF|M_IDLE, 8'h00, 4'd5}  // R5
  };

  int n_tests = 0;
  int n_fail  = 0;
  logic [6:0] obs;
  logic [7:0] seen_byte;

  task automatic sample();
    obs |= {byte_valid, sym_error, bus_break, bus_idle, frame_end, data_end, frame_start};
    if (byte_valid) seen_byte = byte_data;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    obs = '0;
    for (int i = 0; i < n; i++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        sample();
        if (i == 0 && p == 0) bus_in = lvl;
        us_tick = (p == 0);
      end
    end
  endtask

  function automatic logic [31:0] all_outs();
    return {16'h0, byte_data, 1'b0, byte_valid, frame_start, data_end,
            frame_end, bus_idle, bus_break, sym_error};
  endfunction

  initial begin
    #(150000 * 4);
    n_fail++;
    $display("FAIL R12 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; us_tick = 1'b0; bus_in = 1'b0;
    repeat (5) @(negedge clk);
    check("R12 reset outputs", all_outs(), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      hold(VECS[i].lvl, int'(VECS[i].dur));
      check($sformatf("R%0d vec %0d flags", VECS[i].req, i), 32'(obs), 32'(VECS[i].mask));
      if (VECS[i].mask[6])
        check($sformatf("R11 vec %0d byte", i), 32'(seen_byte), 32'(VECS[i].dat));
    end

    // R12: reset in the middle of a frame
    hold(1'b1, 200);
    hold(1'b0, 128);
    hold(1'b1, 128);
    @(negedge clk);
    rst_n = 1'b0; bus_in = 1'b0; us_tick = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 mid-frame reset outputs", all_outs(), 32'h0);
    rst_n = 1'b1;
    hold(1'b0, 200);
    check("R12 no frame after reset", 32'(obs), 32'h0);
    hold(1'b1, 64);
    check("R12 quiet passive end", 32'(obs), 32'h0);
    hold(1'b0, 64);
    check("R9 bit after reset is outside frame", 32'(obs), 32'(M_ERR));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule